// File: doc/BRIEF.md
# EEPROM Page-Write Latch Controller

This block sits between a two-wire serial protocol engine and a nonvolatile memory array. The engine reports bus events to it as single-cycle strobes: a START or STOP condition, a matched device command, a received word address and each received data byte. The block collects the data bytes of a byte write or a page write into a page-wide staging latch, and it keeps a mask of which latch lanes were filled. It advances the in-page byte offset after every byte and wraps that offset inside the page.

A STOP that closes a write holding at least one byte starts a self-timed programming cycle. The cycle lasts a parameterised number of clock cycles. When the cycle ends, only the lanes that were filled are copied into the addressed page row. While the cycle runs, the block reports busy and refuses new commands. A write-protect input that is high when the STOP arrives cancels the commit. A behavioural cell array stands in for the memory, and it is read through a plain combinational read port.

Top module: `page_write_latch`

## Requirements
- R1: After each accepted data byte, the offset (`curAddr[OFF_W-1:0]`, the low five bits with a 32-byte page) increases by one and the page bits `curAddr[ADDR_W-1:OFF_W]` stay unchanged.
- R2: When more bytes arrive than a page holds, the offset wraps from PAGE_BYTES-1 to 0. A later byte for the same offset replaces the earlier latched byte, and only the last value is programmed.
- R3: A commit changes only the page cells whose offsets received a byte. Every other cell, in the same page and in other pages, keeps its previous value.
- R4: Programming starts only on a STOP that follows at least one data byte. A STOP after zero data bytes, or a START that interrupts a write, discards the latch and leaves busy low.
- R5: `busy` rises in the cycle after the STOP strobe and stays high for exactly PROG_CYCLES cycles. The latched bytes appear in the array when `busy` falls, and the block then returns to idle.
- R6: Outside programming, a `cmdReq` strobe yields a one-cycle `cmdAck` in the following cycle. While `busy` is high, `cmdReq` gets no acknowledge, and address and data strobes have no effect on `curAddr`.
- R7: If `wpIn` is high when the STOP arrives, no programming takes place: `busy` stays low and the array is unchanged. Reads through `rdAddr`/`rdData` work whatever the level of `wpIn`.
- R8: After a write sequence, `curAddr` points one past the last written location, with the offset wrapped inside the page. This is the start address for a following current-address read.
- R9: After reset, `busy` and `cmdAck` are low, `curAddr` is 0 and every array cell reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEvt | input | 1 | START condition strobe |
| stopEvt | input | 1 | STOP condition strobe |
| cmdReq | input | 1 | Device command matched; asks for acknowledge |
| addrLoad | input | 1 | Word address received strobe |
| addrIn | input | ADDR_W | Word address (page bits above offset bits) |
| dataValid | input | 1 | Data byte received strobe |
| dataIn | input | 8 | Received data byte |
| wpIn | input | 1 | Write protect, high blocks programming |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array read data (combinational) |
| busy | output | 1 | Self-timed programming in progress |
| cmdAck | output | 1 | Command acknowledge, one cycle after cmdReq |
| curAddr | output | ADDR_W | Current address counter |

## Verification
The bound checker watches, on every cycle, the timing relations between strobes and status. It checks that busy rises only after a STOP, that each busy window has the exact length, that no acknowledge follows a busy cycle, that write protect or a START keeps busy low, that the page bits stay fixed while bytes are latched, and that the address stays frozen during programming. Whether the right bytes land in the right cells cannot be seen at the ports on a single cycle. Lane masking on partial pages, overwrite after wrap, the discard of interrupted or empty writes, and array contents left intact under write protect are therefore shown only by the scoreboard, which compares array reads against a reference model after each scenario.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  typedef struct packed {
    logic loadAddr;
    logic latchByte;
    logic clearLatch;
    logic commit;
  } pwl_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwl_state_t;

endpackage

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
#(
  parameter int PROG_CYCLES = 500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEvt,
  input  logic        stopEvt,
  input  logic        cmdReq,
  input  logic        addrLoad,
  input  logic        dataValid,
  input  logic        wpIn,
  output pwl_strobe_t strb,
  output logic        busy,
  output logic        cmdAck
);

  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(PROG_CYCLES - 1);

  pwl_state_t state, nextState;
  logic [TW-1:0] timer;
  logic haveData;

  always_comb begin
    strb = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (addrLoad) begin
          strb.loadAddr   = 1'b1;
          strb.clearLatch = 1'b1;
          nextState       = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (startEvt) begin
          strb.clearLatch = 1'b1;
          nextState       = ST_IDLE;
        end else if (stopEvt) begin
          if (haveData && !wpIn) begin
            nextState = ST_PROG;
          end else begin
            strb.clearLatch = 1'b1;
            nextState       = ST_IDLE;
          end
        end else if (dataValid) begin
          strb.latchByte = 1'b1;
        end else if (addrLoad) begin
          strb.loadAddr   = 1'b1;
          strb.clearLatch = 1'b1;
        end
      end
      ST_PROG: begin
        if (timer == LAST) begin
          strb.commit = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      haveData <= 1'b0;
      cmdAck   <= 1'b0;
    end else begin
      state  <= nextState;
      timer  <= (state == ST_PROG) ? timer + 1'b1 : '0;
      cmdAck <= cmdReq && (state != ST_PROG);
      if (strb.clearLatch || strb.commit) haveData <= 1'b0;
      else if (strb.latchByte)            haveData <= 1'b1;
    end
  end

  assign busy = (state == ST_PROG);

endmodule

// File: rtl/pwl_datapath.sv
module pwl_datapath
  import pwl_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 16,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int ADDR_W = OFF_W + PG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwl_strobe_t       strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int DEPTH = PAGE_BYTES * NUM_PAGES;

  logic [PG_W-1:0]       pageReg;
  logic [OFF_W-1:0]      offReg;
  logic [7:0]            latchMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [7:0]            cellMem  [DEPTH];

  // address counter: only the offset moves on a data byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg <= '0;
      offReg  <= '0;
    end else if (strb.loadAddr) begin
      pageReg <= addrIn[ADDR_W-1:OFF_W];
      offReg  <= addrIn[OFF_W-1:0];
    end else if (strb.latchByte) begin
      offReg <= offReg + 1'b1;
    end
  end

  // one staging lane per byte of the page
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic [7:0] hold;
    logic       filled;
    logic       hit;

    assign hit = strb.latchByte && (offReg == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hold   <= '0;
        filled <= 1'b0;
      end else if (strb.clearLatch || strb.commit) begin
        filled <= 1'b0;
      end else if (hit) begin
        hold   <= dataIn;
        filled <= 1'b1;
      end
    end

    assign latchMem[g]  = hold;
    assign validMask[g] = filled;
  end

  // behavioural cell array, erased state after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cellMem[i] <= 8'hFF;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (validMask[i]) cellMem[{pageReg, OFF_W'(i)}] <= latchMem[i];
      end
    end
  end

  assign rdData  = cellMem[rdAddr];
  assign curAddr = {pageReg, offReg};

endmodule

// File: rtl/page_write_latch.sv
module page_write_latch
  import pwl_pkg::*;
#(
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 16,
  parameter int PROG_CYCLES = 500000,
  localparam int ADDR_W = $clog2(PAGE_BYTES) + $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic              cmdReq,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [7:0]        dataIn,
  input  logic              wpIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              cmdAck,
  output logic [ADDR_W-1:0] curAddr
);

  pwl_strobe_t strb;

  pwl_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startEvt  (startEvt),
    .stopEvt   (stopEvt),
    .cmdReq    (cmdReq),
    .addrLoad  (addrLoad),
    .dataValid (dataValid),
    .wpIn      (wpIn),
    .strb      (strb),
    .busy      (busy),
    .cmdAck    (cmdAck)
  );

  pwl_datapath #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .curAddr (curAddr)
  );

endmodule

// File: rtl/pwl_checker.sv
module pwl_checker #(
  parameter int PAGE_BYTES  = 32,
  parameter int NUM_PAGES   = 16,
  parameter int PROG_CYCLES = 500000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = OFF_W + $clog2(NUM_PAGES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startEvt,
  input logic              stopEvt,
  input logic              cmdReq,
  input logic              addrLoad,
  input logic              dataValid,
  input logic              wpIn,
  input logic              busy,
  input logic              cmdAck,
  input logic [ADDR_W-1:0] curAddr
);

  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == PROG_CYCLES));

  assert_no_ack_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |-> !$past(busy));

  assert_addr_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curAddr));

  assert_wp_blocks_prog_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopEvt && wpIn && !busy) |=> !busy);

  assert_start_discards_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startEvt && !busy) |=> !busy);

  assert_page_bits_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !addrLoad && !busy) |=>
      (curAddr[ADDR_W-1:OFF_W] == $past(curAddr[ADDR_W-1:OFF_W])));

endmodule

bind page_write_latch pwl_checker #(
  .PAGE_BYTES (PAGE_BYTES),
  .NUM_PAGES  (NUM_PAGES),
  .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startEvt (startEvt),
  .stopEvt  (stopEvt),
  .cmdReq   (cmdReq),
  .addrLoad (addrLoad),
  .dataValid(dataValid),
  .wpIn     (wpIn),
  .busy     (busy),
  .cmdAck   (cmdAck),
  .curAddr  (curAddr)
);

// File: tb/page_write_latch_bench.sv
module page_write_latch_bench;

  localparam int PB     = 32;
  localparam int NP     = 16;
  localparam int PROG   = 20;
  localparam int AW     = 9;
  localparam int DEPTH  = PB * NP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEvt = 0, stopEvt = 0, cmdReq = 0, addrLoad = 0, dataValid = 0, wpIn = 0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] rdData;
  logic busy, cmdAck;
  logic [AW-1:0] curAddr;

  always #5 clk = ~clk;

  page_write_latch #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .PROG_CYCLES(PROG)) u_page_write_latch (
    .clk(clk), .rstN(rstN), .startEvt(startEvt), .stopEvt(stopEvt), .cmdReq(cmdReq),
    .addrLoad(addrLoad), .addrIn(addrIn), .dataValid(dataValid), .dataIn(dataIn),
    .wpIn(wpIn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .cmdAck(cmdAck),
    .curAddr(curAddr)
  );

  typedef struct {
    int    addr;
    int    exp;
    string req;
  } sb_item_t;

  sb_item_t sbQ[$];
  int checks = 0;
  int fails = 0;
  logic [7:0] refMem [DEPTH];
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: drives the read port and compares with the model
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        sb_item_t it;
        it = sbQ.pop_front();
        rdAddr = AW'(it.addr);
        #1;
        check(rdData == 8'(it.exp), it.req, $sformatf("cell 0x%0h", it.addr), rdData, it.exp);
      end
    end
  end

  task automatic expectCell(input int a, input string req);
    sb_item_t it;
    it.addr = a; it.exp = refMem[a]; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic expectPage(input int pg, input string req);
    for (int i = -1; i <= PB; i++) begin
      int a = pg * PB + i;
      if (a >= 0 && a < DEPTH) expectCell(a, req);
    end
  endtask

  task automatic drain();
    wait (sbQ.size() == 0);
    @(negedge clk);
    #2;
  endtask

  function automatic logic [7:0] genByte(input int seed, input int i);
    return 8'(seed * 7 + i * 13 + 1);
  endfunction

  task automatic doStart();
    @(negedge clk); startEvt = 1;
    @(negedge clk); startEvt = 0;
  endtask

  task automatic doStop();
    @(negedge clk); stopEvt = 1;
    @(negedge clk); stopEvt = 0;
  endtask

  task automatic doAddr(input int a);
    @(negedge clk); addrLoad = 1; addrIn = AW'(a);
    @(negedge clk); addrLoad = 0;
  endtask

  task automatic doData(input logic [7:0] b);
    @(negedge clk); dataValid = 1; dataIn = b;
    @(negedge clk); dataValid = 0;
  endtask

  task automatic doCmd(input bit expAck, input string req);
    @(negedge clk); cmdReq = 1;
    @(negedge clk); cmdReq = 0;
    check(cmdAck == expAck, req, "cmdAck", cmdAck, expAck);
  endtask

  // full write transaction; endStop=0 ends it with an interrupting START
  task automatic writeSeq(input int a, input int n, input int seed, input bit endStop, input bit wp);
    int pg = a / PB;
    int off = a % PB;
    bit prog;
    wpIn = wp;
    doStart();
    doCmd(1'b1, "R6");
    doAddr(a);
    for (int i = 0; i < n; i++) begin
      doData(genByte(seed, i));
      check(curAddr == AW'(pg * PB + (off + i + 1) % PB), "R1", "curAddr per byte",
            curAddr, pg * PB + (off + i + 1) % PB);
    end
    if (endStop) doStop(); else doStart();
    check(curAddr == AW'(pg * PB + (off + n) % PB), "R8", "curAddr after write",
          curAddr, pg * PB + (off + n) % PB);
    prog = endStop && (n > 0) && !wp;
    if (prog) begin
      bit held = 1;
      check(busy == 1'b1, "R5", "busy after stop", busy, 1);
      repeat (PROG - 1) begin
        @(negedge clk);
        if (!busy) held = 0;
      end
      check(held, "R5", "busy held", held, 1);
      @(negedge clk);
      check(busy == 1'b0, "R5", "busy cleared", busy, 0);
      for (int i = 0; i < n; i++) refMem[pg * PB + (off + i) % PB] = genByte(seed, i);
    end else begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, wp ? "R7" : "R4", "busy stays low", busy, 0);
    end
    wpIn = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R9 reset state
    check(busy == 1'b0, "R9", "busy at reset", busy, 0);
    check(cmdAck == 1'b0, "R9", "cmdAck at reset", cmdAck, 0);
    check(curAddr == '0, "R9", "curAddr at reset", curAddr, 0);
    expectPage(0, "R9");
    expectCell(DEPTH - 1, "R9");
    drain();

    // R3 byte write: neighbours untouched
    writeSeq(1 * PB + 5, 1, 3, 1'b1, 1'b0);
    expectPage(1, "R3");
    drain();

    // R3 partial page of 6 bytes into page 2
    writeSeq(2 * PB + 12, 6, 9, 1'b1, 1'b0);
    expectPage(2, "R3");
    drain();

    // R2 wrap: 40 bytes from offset 10 overwrite the first eight
    writeSeq(3 * PB + 10, 40, 21, 1'b1, 1'b0);
    expectPage(3, "R2");
    drain();

    // R2 wrap from the last offset of the last page
    writeSeq(DEPTH - 1, 3, 33, 1'b1, 1'b0);
    expectPage(NP - 1, "R2");
    drain();

    // R4 STOP after zero data bytes
    writeSeq(4 * PB, 0, 5, 1'b1, 1'b0);
    expectPage(4, "R4");
    drain();

    // R4 START interrupts a write of three bytes
    writeSeq(5 * PB + 2, 3, 7, 1'b0, 1'b0);
    expectPage(5, "R4");
    drain();

    // R7 write protect blocks a page write; reads still served with wp high
    writeSeq(2 * PB + 12, 4, 41, 1'b1, 1'b1);
    wpIn = 1;
    expectPage(2, "R7");
    drain();
    wpIn = 0;

    // R6 busy refuses commands and ignores address/data
    begin
      logic [AW-1:0] held;
      doStart();
      doCmd(1'b1, "R6");
      doAddr(6 * PB + 1);
      doData(8'hA5);
      doStop();
      held = curAddr;
      doCmd(1'b0, "R6");
      doAddr(9 * PB + 3);
      doData(8'h3C);
      check(curAddr == held, "R6", "curAddr during busy", curAddr, held);
      for (int k = 0; k < 4 * PROG && busy; k++) @(negedge clk);
      check(busy == 1'b0, "R6", "busy ended", busy, 0);
      refMem[6 * PB + 1] = 8'hA5;
      doCmd(1'b1, "R6");
      expectPage(6, "R6");
      expectPage(9, "R6");
      drain();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule